// File: doc/BRIEF.md
# Early-Release Write Strobe Shaper

This block derives a bus write strobe from a CPU's active-low write strobe. The bus strobe goes low at the same instant as the CPU strobe, with no clock in the path. It then goes high again after a fixed number of CPU clock rising edges, while the CPU strobe is still low. A peripheral that latches address and data on the rising edge of its write input therefore sees that edge well before the CPU lets go of the address and data lines. It gets extra hold time, where it would otherwise have only the few nanoseconds between the CPU strobe rising and the lines being released.

The release point is the `RELEASE_CNT` parameter, counted in CPU clocks. When the bus runs at three or four CPU clocks per bus state, a write-low period spans several CPU clocks, and `RELEASE_CNT` must be set below that span. A value of zero stops elaboration with an error. The shaper rearms once the CPU strobe has been high across at least one rising clock edge.

Top module: `wr_hold_shaper`

## Requirements
- R1: After a synchronous reset, with the CPU strobe high, the bus strobe is high. The first strobe after reset then gives the full low width of R3.
- R2: The bus strobe goes low in the same time step as the CPU strobe falls. No clock edge is needed.
- R3: If the CPU strobe stays low for L clock periods, measured from a fall between edges, the bus strobe stays low for min(L, RELEASE_CNT) clock periods. The low period is one contiguous run that starts at the fall.
- R4: The bus strobe is never low while the CPU strobe is high. If the CPU strobe rises before the release point, the bus strobe rises with it in the same time step.
- R5: After the CPU strobe has been high across one rising clock edge, the block is rearmed. The next strobe again gives the full width of R3.
- R6: Once released, the bus strobe stays high for the rest of a long CPU strobe. The count saturates and never wraps back into a second low pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| bus_wr_n | output | 1 | Shaped bus write strobe, active low |

## Verification
The embedded properties check the internal sequencing on every cycle:
- the counter steps by one while the strobe is low;
- the counter saturates at its terminal value and clears when the strobe is high;
- the release flag rises only on the edge after the terminal count, holds for the rest of the strobe, and drops when the strobe returns high.

Some behaviours happen between clock edges or are visible only at the port, so only the bench scenarios can show them:
- the zero-latency falling edge;
- the immediate rise on an early CPU release;
- the exact low width for strobes shorter than, equal to and longer than the release count;
- the rearm after a one-cycle gap.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    // Release flag state: armed waits for the terminal count, released holds the bus strobe high.
    typedef enum logic {
        REL_ARMED    = 1'b0,
        REL_RELEASED = 1'b1
    } rel_state_e;

    // Width needed to hold the terminal value n-1, at least one bit.
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wrs_counter.sv
module wrs_counter #(
    parameter int TERM  = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe_low,
    output logic [CNT_W-1:0] cnt,
    output logic             at_term
);

    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

    assign at_term = (cnt == TERM_V);

    always_ff @(posedge clk) begin
        if (rst || !strobe_low) begin
            cnt <= '0;
        end else if (!at_term) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !strobe_low |=> (cnt == '0)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (strobe_low && cnt != TERM_V) |=> (cnt == $past(cnt) + 1'b1)); // R3

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (strobe_low && cnt == TERM_V) |=> (cnt == TERM_V)); // R6

endmodule

// File: rtl/wrs_release_flag.sv
module wrs_release_flag
    import wrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_low,
    input  logic at_term,
    output logic released
);

    rel_state_e state;

    always_ff @(posedge clk) begin
        if (rst || !strobe_low) begin
            state <= REL_ARMED;
        end else if (at_term) begin
            state <= REL_RELEASED;
        end
    end

    assign released = (state == REL_RELEASED);

    AST_REL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !strobe_low |=> !released); // R5

    AST_REL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (released && strobe_low) |=> released); // R6

endmodule

// File: rtl/wr_hold_shaper.sv
module wr_hold_shaper #(
    parameter int RELEASE_CNT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic cpu_wr_n,
    output logic bus_wr_n
);

    localparam int TERM  = (RELEASE_CNT > 0) ? RELEASE_CNT - 1 : 0;
    localparam int CNT_W = wrs_pkg::cnt_width(RELEASE_CNT);

    generate
        if (RELEASE_CNT < 1) begin : g_bad_count
            $error("wr_hold_shaper: RELEASE_CNT must be at least 1");
        end
    endgenerate

    logic             strobe_low;
    logic [CNT_W-1:0] cnt;
    logic             at_term;
    logic             released;

    assign strobe_low = !cpu_wr_n;

    wrs_counter #(
        .TERM  (TERM),
        .CNT_W (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst        (rst),
        .strobe_low (strobe_low),
        .cnt        (cnt),
        .at_term    (at_term)
    );

    wrs_release_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .strobe_low (strobe_low),
        .at_term    (at_term),
        .released   (released)
    );

    // Falling edge passes straight through; only the rising edge is clocked.
    assign bus_wr_n = cpu_wr_n | released;

    AST_REL_AT_TERM: assert property (@(posedge clk) disable iff (rst)
        (strobe_low && cnt == CNT_W'(TERM)) |=> released); // R3

    AST_REL_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        $rose(released) |-> ($past(cnt) == CNT_W'(TERM) && !$past(cpu_wr_n))); // R3

endmodule

// File: tb/sim_wr_hold_shaper.sv
`timescale 1ns/1ps
module sim_wr_hold_shaper;

    localparam int N = 5;
    localparam int NV = 7;
    localparam int LENS [NV] = '{1, 2, 4, 5, 6, 9, 40};
    localparam int EXPW [NV] = '{1, 2, 4, 5, 5, 5, 5};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_wr_n = 1'b1;
    logic bus_wr_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wr_hold_shaper #(.RELEASE_CNT(N)) u0 (
        .clk      (clk),
        .rst      (rst),
        .cpu_wr_n (cpu_wr_n),
        .bus_wr_n (bus_wr_n)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // One CPU strobe of len clocks low, then gap clocks high; checks R2, R3, R4, R6.
    task automatic strobe(input int len, input int gap, input int exp_w);
        int lows = 0;
        int rises = 0;
        int prev = 0;
        int high_low = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            cpu_wr_n = 1'b0;
            #1;
            if (i == 0) check("R2 fall without latency", bus_wr_n, 0);
            if (bus_wr_n == 1'b0) lows++;
            if (i > 0 && prev == 1 && bus_wr_n == 1'b0) rises++;
            prev = bus_wr_n;
        end
        for (int j = 0; j < gap; j++) begin
            @(negedge clk);
            cpu_wr_n = 1'b1;
            #1;
            if (bus_wr_n == 1'b0) high_low++;
        end
        check("R3 low width", lows, exp_w);
        check("R6 no second low pulse", rises, 0);
        check("R4 bus high while cpu high", high_low, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 output high in reset", bus_wr_n, 1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 output high after reset", bus_wr_n, 1);
        // First strobe after reset must be the full width (R1).
        strobe(8, 2, N);

        for (int v = 0; v < NV; v++) begin
            strobe(LENS[v], 2, EXPW[v]);
        end

        // R4: early CPU rise, bus follows in the same time step.
        @(negedge clk); cpu_wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk); cpu_wr_n = 1'b1;
        #1;
        check("R4 immediate rise on early release", bus_wr_n, 1);
        @(negedge clk);

        // R5: rearm after one high clock between strobes.
        strobe(8, 1, N);
        strobe(8, 1, N);
        strobe(3, 1, 3);
        strobe(7, 2, N);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule